// File: doc/BRIEF.md
# Multi-Word Transfer Prefix Unit

This unit stores the prefix flags that turn a single register-to-register move, or a single load/store through a memory pointer, into a run of consecutive transfers. Prefix instructions raise one of four count flags, a byte flag, or both. The count flags give runs of 2, 3, 4 or 8 transfers. When several count flags are set, the largest run applies.

While the run is unfinished, the unit tells the sequencer to repeat the active transfer state. On every step it gives the datapath three things: the destination register index, the address increment, and the word or byte formatting of the loaded value. When the final step completes, all flags clear by themselves. An instruction that cannot take prefixes also clears them, and it runs only once.

The sequencer raises a step strobe for each cycle in which a transfer state is active. It reports the kind of transfer in that cycle, and it acknowledges the step once the data has actually moved. A step without an acknowledge is a stall and does not advance the run.

Top module: `mwp_prefix_unit`

## Requirements
- R1: After reset no flag is set: `rpt_o` is 0, `dst_idx_o` equals `dst_base_i`, `addr_step_o` is 2 and `byte_mode_o` is 0.
- R2: Count-set bits 0, 1, 2 and 3 of `cnt_set_i` select runs of 2, 3, 4 and 8 transfers. With several bits set, the largest run applies. With none set, the run is 1.
- R3: During a step of a usable kind (`xfer_kind_i` 2'b01 = register move, 2'b10 = memory through pointer), `rpt_o` is 1 unless the step is acknowledged and is the last step of the run.
- R4: A step with `step_ack_i` low does not advance the run. The same register index is presented on the next step, and `rpt_o` stays 1.
- R5: `dst_idx_o` is `dst_base_i` plus the number of completed steps, modulo 8, so it wraps from 7 to 0.
- R6: `addr_step_o` is 2 in word mode and 1 in byte mode.
- R7: Byte mode is active only when the byte flag is set and the kind is memory. In byte mode, `wb_data_o` is the byte of `rd_data_i` chosen by `byte_sel_i` (0 = bits 7:0, 1 = bits 15:8), zero-extended. In word mode, `rd_data_i` passes through unchanged.
- R8: For a register move, the byte flag has no effect: word mode, step 2, data unchanged.
- R9: A step of an unusable kind (2'b00 or 2'b11) gives `rpt_o` = 0 and clears every flag.
- R10: After the acknowledged last step of a run, all flags and the step position are cleared, so the next instruction is a single word transfer.
- R11: A prefix set strobe that arrives in the same cycle as a clearing step survives and applies to the next instruction.
- R12: The byte flag with no count flag on a memory access gives exactly one byte transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_set_i | input | 4 | Count-flag set strobes (bit n selects run 2/3/4/8) |
| byte_set_i | input | 1 | Byte-flag set strobe |
| step_vld_i | input | 1 | A transfer state is active this cycle |
| step_ack_i | input | 1 | The transfer of this step completed |
| xfer_kind_i | input | 2 | 00 none, 01 register move, 10 memory via pointer, 11 none |
| dst_base_i | input | 3 | Destination register named by the instruction |
| rd_data_i | input | 16 | Data read for the current step |
| byte_sel_i | input | 1 | Byte lane of the current address |
| rpt_o | output | 1 | Repeat the active state next cycle |
| dst_idx_o | output | 3 | Destination register for this step |
| byte_mode_o | output | 1 | Current step moves a byte |
| addr_step_o | output | 2 | Address increment for this step |
| wb_data_o | output | 16 | Formatted data for the register write |

## Verification
Two events can share a single cycle: the final acknowledged step that clears the flags, and a prefix set strobe meant for the following instruction. The bench drives a set strobe on exactly that closing step. It then checks that the next instruction runs for the newly selected length and not as a single transfer. A second overlap is a stall on a step that would otherwise be the last one. Here the bench expects `rpt_o` to stay high and the register index to stay fixed until the acknowledge arrives.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

  localparam int unsigned CNT_FLAGS = 4;
  localparam int unsigned MAX_RUN   = 8;
  localparam int unsigned RUN_W     = $clog2(MAX_RUN) + 1;
  localparam int unsigned POS_W     = $clog2(MAX_RUN);

  typedef enum logic [1:0] {
    XK_NONE = 2'b00,
    XK_MOV  = 2'b01,
    XK_MEM  = 2'b10,
    XK_RSVD = 2'b11
  } xfer_kind_e;

  // largest selected run wins
  function automatic logic [RUN_W-1:0] run_len(input logic [CNT_FLAGS-1:0] f);
    logic [RUN_W-1:0] r;
    if (f[3])      r = RUN_W'(8);
    else if (f[2]) r = RUN_W'(4);
    else if (f[1]) r = RUN_W'(3);
    else if (f[0]) r = RUN_W'(2);
    else           r = RUN_W'(1);
    return r;
  endfunction

  function automatic logic kind_usable(input xfer_kind_e k);
    return (k == XK_MOV) || (k == XK_MEM);
  endfunction

endpackage

// File: rtl/mwp_rst_sync.sv
module mwp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mwp_flags.sv
module mwp_flags
  import mwp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_FLAGS-1:0] cnt_set_i,
  input  logic                 byte_set_i,
  input  logic                 clr_i,
  output logic [CNT_FLAGS-1:0] cnt_flags_o,
  output logic                 byte_flag_o
);
  logic [CNT_FLAGS-1:0] cnt_q, cnt_d;
  logic                 byte_q, byte_d;
  logic                 upd_en;

  always_comb begin
    upd_en = clr_i || (|cnt_set_i) || byte_set_i;
    // set strobes override a same-cycle clear
    cnt_d  = (clr_i ? '0 : cnt_q) | cnt_set_i;
    byte_d = (clr_i ? 1'b0 : byte_q) | byte_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      byte_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
    end
  end

  assign cnt_flags_o = cnt_q;
  assign byte_flag_o = byte_q;

  // R11
  set_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && |cnt_set_i) |=> ((cnt_q & $past(cnt_set_i)) == $past(cnt_set_i)));
endmodule

// File: rtl/mwp_step_ctr.sv
module mwp_step_ctr #(
  parameter int unsigned POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  always_comb begin
    pos_en = adv_i || clr_i;
    pos_d  = clr_i ? '0 : pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  // R5
  pos_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i) |=> (pos_q == $past(pos_q) + POS_W'(1)));
  // R4
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(pos_q));
endmodule

// File: rtl/mwp_lane.sv
module mwp_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned POS_W  = 3
) (
  input  logic [IDX_W-1:0]  base_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              byte_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        step_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] lane_b;

  always_comb begin
    idx_o  = base_i + IDX_W'(pos_i);
    step_o = byte_i ? 2'd1 : 2'd2;
    lane_b = sel_i ? data_i[DATA_W-1:BYTE_W] : data_i[BYTE_W-1:0];
    data_o = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, lane_b} : data_i;
  end

  // R6
  always_comb begin
    step_range_chk: assert ((step_o == 2'd1) || (step_o == 2'd2));
  end
endmodule

// File: rtl/mwp_prefix_unit.sv
module mwp_prefix_unit
  import mwp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [3:0]                  cnt_set_i,
  input  logic                        byte_set_i,
  input  logic                        step_vld_i,
  input  logic                        step_ack_i,
  input  logic [1:0]                  xfer_kind_i,
  input  logic [$clog2(NUM_REGS)-1:0] dst_base_i,
  input  logic [DATA_W-1:0]           rd_data_i,
  input  logic                        byte_sel_i,
  output logic                        rpt_o,
  output logic [$clog2(NUM_REGS)-1:0] dst_idx_o,
  output logic                        byte_mode_o,
  output logic [1:0]                  addr_step_o,
  output logic [DATA_W-1:0]           wb_data_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic                 rst_n_s;
  logic [CNT_FLAGS-1:0] cnt_flags;
  logic                 byte_flag;
  logic [POS_W-1:0]     pos;
  logic [RUN_W-1:0]     run;
  xfer_kind_e           kind;
  logic                 usable, last, done_step, fin, clr, adv;

  mwp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  mwp_flags u_flags (
    .clk(clk), .rst_n(rst_n_s),
    .cnt_set_i(cnt_set_i), .byte_set_i(byte_set_i), .clr_i(clr),
    .cnt_flags_o(cnt_flags), .byte_flag_o(byte_flag)
  );

  mwp_step_ctr #(.POS_W(POS_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .adv_i(adv), .clr_i(clr), .pos_o(pos)
  );

  always_comb begin
    kind        = xfer_kind_e'(xfer_kind_i);
    usable      = kind_usable(kind);
    run         = run_len(cnt_flags);
    last        = ({1'b0, pos} + RUN_W'(1)) == run;
    done_step   = step_vld_i && step_ack_i && usable;
    fin         = done_step && last;
    adv         = done_step && !last;
    clr         = fin || (step_vld_i && !usable);
    rpt_o       = step_vld_i && usable && !(step_ack_i && last);
    byte_mode_o = byte_flag && (kind == XK_MEM);
  end

  mwp_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_lane (
    .base_i(dst_base_i), .pos_i(pos), .byte_i(byte_mode_o),
    .sel_i(byte_sel_i), .data_i(rd_data_i),
    .idx_o(dst_idx_o), .step_o(addr_step_o), .data_o(wb_data_o)
  );

  // R3
  rpt_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rpt_o |-> step_vld_i);
  // R8
  mov_word_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (kind == XK_MOV) |-> (addr_step_o == 2'd2 && wb_data_o == rd_data_i));
  // R9
  none_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (step_vld_i && !usable && cnt_set_i == '0 && !byte_set_i)
      |=> (cnt_flags == '0 && !byte_flag && pos == '0));
  // R10
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (step_vld_i && step_ack_i && usable && !rpt_o && cnt_set_i == '0 && !byte_set_i)
      |=> (cnt_flags == '0 && !byte_flag && pos == '0));
endmodule

// File: tb/mwp_prefix_unit_bench.sv
module mwp_prefix_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cnt_set_i;
  logic        byte_set_i, step_vld_i, step_ack_i, byte_sel_i;
  logic [1:0]  xfer_kind_i;
  logic [2:0]  dst_base_i;
  logic [15:0] rd_data_i;
  logic        rpt_o, byte_mode_o;
  logic [2:0]  dst_idx_o;
  logic [1:0]  addr_step_o;
  logic [15:0] wb_data_o;

  typedef struct {
    logic        rep;
    logic [2:0]  idx;
    logic        bm;
    logic [1:0]  stp;
    logic [15:0] dat;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // bench reference state
  logic [3:0] m_flags = '0;
  logic       m_byte  = 1'b0;
  int         m_pos   = 0;
  logic       last_rep;

  always #5 clk = ~clk;

  mwp_prefix_unit u_mwp_prefix_unit (
    .clk(clk), .rst_n(rst_n), .cnt_set_i(cnt_set_i), .byte_set_i(byte_set_i),
    .step_vld_i(step_vld_i), .step_ack_i(step_ack_i), .xfer_kind_i(xfer_kind_i),
    .dst_base_i(dst_base_i), .rd_data_i(rd_data_i), .byte_sel_i(byte_sel_i),
    .rpt_o(rpt_o), .dst_idx_o(dst_idx_o), .byte_mode_o(byte_mode_o),
    .addr_step_o(addr_step_o), .wb_data_o(wb_data_o)
  );

  function automatic int run_of(input logic [3:0] f);
    if (f[3]) return 8;
    if (f[2]) return 4;
    if (f[1]) return 3;
    if (f[0]) return 2;
    return 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each active step against the scoreboard
  always @(negedge clk) begin
    if (!done && step_vld_i) begin
      if (exp_q.size() == 0) chk("scoreboard underrun", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " rpt"},  {31'b0, rpt_o},       {31'b0, e.rep});
        chk({e.tag, " idx"},  {29'b0, dst_idx_o},   {29'b0, e.idx});
        chk({e.tag, " byte"}, {31'b0, byte_mode_o}, {31'b0, e.bm});
        chk({e.tag, " step"}, {30'b0, addr_step_o}, {30'b0, e.stp});
        chk({e.tag, " data"}, {16'b0, wb_data_o},   {16'b0, e.dat});
      end
    end
  end

  // driver: one cycle of stimulus, expectation pushed from the requirements
  task automatic cyc(input logic vld, input logic [1:0] kind, input logic [2:0] base,
                     input logic ack, input logic [15:0] d, input logic sel,
                     input logic [3:0] cset, input logic bset, input string tag);
    exp_t e;
    int   run;
    logic use_k, lst, clr;
    @(posedge clk); #1;
    step_vld_i = vld; xfer_kind_i = kind; dst_base_i = base; step_ack_i = ack;
    rd_data_i = d; byte_sel_i = sel; cnt_set_i = cset; byte_set_i = bset;
    use_k = (kind == 2'b01) || (kind == 2'b10);
    run   = run_of(m_flags);
    lst   = (m_pos + 1 == run);
    clr   = 1'b0;
    if (vld) begin
      e.rep = use_k && !(ack && lst);
      e.idx = 3'((int'(base) + m_pos) % 8);
      e.bm  = m_byte && (kind == 2'b10);
      e.stp = e.bm ? 2'd1 : 2'd2;
      e.dat = e.bm ? {8'h00, (sel ? d[15:8] : d[7:0])} : d;
      e.tag = tag;
      last_rep = e.rep;
      exp_q.push_back(e);
      if (!use_k) clr = 1'b1;
      else if (ack) begin
        if (lst) clr = 1'b1;
        else m_pos++;
      end
    end
    if (clr) begin m_flags = '0; m_byte = 1'b0; m_pos = 0; end
    m_flags = m_flags | cset;
    m_byte  = m_byte | bset;
  endtask

  task automatic idle();
    cyc(1'b0, 2'b00, 3'd0, 1'b0, 16'h0, 1'b0, 4'h0, 1'b0, "idle");
  endtask

  task automatic prefix(input logic [3:0] cset, input logic bset);
    cyc(1'b0, 2'b00, 3'd0, 1'b0, 16'h0, 1'b0, cset, bset, "prefix");
  endtask

  task automatic run_xfer(input logic [1:0] kind, input logic [2:0] base, input string tag,
                          output int steps);
    steps = 0;
    do begin
      cyc(1'b1, kind, base, 1'b1, 16'hC35A ^ 16'(steps * 16'h1111), steps[0],
          4'h0, 1'b0, tag);
      steps++;
    end while (last_rep && steps < 16);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    step_vld_i = 0; step_ack_i = 0; xfer_kind_i = 2'b10; dst_base_i = 3'd5;
    rd_data_i = 16'h0; byte_sel_i = 0; cnt_set_i = 0; byte_set_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rpt", {31'b0, rpt_o}, 0);
    chk("R1 idx", {29'b0, dst_idx_o}, 5);
    chk("R1 step", {30'b0, addr_step_o}, 2);
    chk("R1 byte", {31'b0, byte_mode_o}, 0);

    // R1 / R10: no prefix gives a single step
    run_xfer(2'b10, 3'd2, "R1 single", n); chk("R1 steps", n, 1);
    // R2, R3, R5: each count flag
    prefix(4'b0001, 0); run_xfer(2'b01, 3'd3, "R2 run2 R3", n); chk("R2 run2", n, 2);
    prefix(4'b0010, 0); run_xfer(2'b10, 3'd6, "R5 wrap run3", n); chk("R2 run3", n, 3);
    prefix(4'b0100, 0); run_xfer(2'b10, 3'd1, "R2 run4", n); chk("R2 run4", n, 4);
    prefix(4'b1000, 0); run_xfer(2'b01, 3'd0, "R5 run8", n); chk("R2 run8", n, 8);
    // R2: largest wins
    prefix(4'b0101, 0); run_xfer(2'b01, 3'd7, "R2 largest", n); chk("R2 largest", n, 4);
    prefix(4'b0011, 0); idle(); run_xfer(2'b10, 3'd4, "R2 largest b", n); chk("R2 largest b", n, 3);

    // R4: stalls in the middle and on the last step
    prefix(4'b0010, 0);
    cyc(1, 2'b10, 3'd2, 1, 16'h1111, 0, 0, 0, "R4 s0");
    cyc(1, 2'b10, 3'd2, 0, 16'h2222, 0, 0, 0, "R4 stall mid");
    cyc(1, 2'b10, 3'd2, 1, 16'h3333, 0, 0, 0, "R4 s1");
    cyc(1, 2'b10, 3'd2, 0, 16'h4444, 0, 0, 0, "R4 stall last");
    cyc(1, 2'b10, 3'd2, 1, 16'h5555, 0, 0, 0, "R4 s2");
    chk("R4 end", {31'b0, last_rep}, 0);

    // R6, R7: byte run on memory, both lanes
    prefix(4'b0100, 1); run_xfer(2'b10, 3'd5, "R7 byte run R6", n); chk("R7 steps", n, 4);
    // R8: byte flag ignored on register move
    prefix(4'b0001, 1); run_xfer(2'b01, 3'd0, "R8 mov", n); chk("R8 steps", n, 2);
    run_xfer(2'b10, 3'd0, "R10 after", n); chk("R10 single", n, 1);

    // R9: unusable kinds clear flags
    prefix(4'b1000, 1);
    cyc(1, 2'b00, 3'd1, 1, 16'hABCD, 1, 0, 0, "R9 none");
    run_xfer(2'b10, 3'd1, "R9 after", n); chk("R9 single", n, 1);
    prefix(4'b0100, 0);
    cyc(1, 2'b11, 3'd1, 1, 16'hABCD, 0, 0, 0, "R9 rsvd");
    run_xfer(2'b01, 3'd1, "R9 after b", n); chk("R9 single b", n, 1);

    // R12: byte alone on memory
    prefix(4'b0000, 1); run_xfer(2'b10, 3'd3, "R12 one byte", n); chk("R12 steps", n, 1);
    run_xfer(2'b10, 3'd3, "R10 word again", n); chk("R10 steps", n, 1);

    // R11: set strobe on the closing step
    prefix(4'b0001, 0);
    cyc(1, 2'b01, 3'd4, 1, 16'h0101, 0, 4'b0000, 0, "R11 s0");
    cyc(1, 2'b01, 3'd4, 1, 16'h0202, 0, 4'b0010, 0, "R11 close+set");
    run_xfer(2'b01, 3'd4, "R11 next", n); chk("R11 steps", n, 3);

    idle(); idle();
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule